// File: doc/BRIEF.md
# SD Card Clock Divider

This block derives the card-side clock from the master clock of a memory card host controller. A single clock control word, held in a register elsewhere in the host and presented here as a parallel input, selects the division ratio, turns the clock on, picks a straight pass-through of the master clock, enables a power-saving idle stop and enables a flow-control stop driven by the data FIFO. The word also carries two bus-width bits, which the block decodes for the data path.

In divided mode the card clock is a register toggling every DIV+1 master cycles, so one card period lasts 2×(DIV+1) master cycles. Alongside it the block drives a qualifier, high in the master cycle in which the card clock has just risen, so that logic running on the master clock can act once per card edge without crossing clock domains. In pass-through mode the master clock is gated by a flop updated on the master falling edge, and the qualifier is high on every master cycle while the gate is open. Every stop condition (disable, FIFO stall, idle bus in power-save mode) parks the card clock low.

Top module: `sdclk_divider`

## Requirements
- R1: With enable (bit 8) set and pass-through (bit 10) clear, the card clock has a period of 2×(DIV+1) master cycles, high for DIV+1 cycles and low for DIV+1 cycles, where DIV is control bits [7:0].
- R2: DIV = 255 gives the slowest card clock, one period every 512 master cycles.
- R3: With enable and pass-through both set, the card clock is high while the master clock is high and low while it is low, whatever DIV holds.
- R4: With enable clear, and during reset, the card clock stays low and the qualifier stays low.
- R5: With the flow-control bit set (bit 13 or bit 14, chosen by a parameter) and the FIFO stall input high, the card clock is held low; with that bit clear the stall input has no effect on the card clock.
- R6: With the power-save bit (bit 9) set, the card clock is held low while the bus-active input is low and runs while it is high.
- R7: A new DIV value takes effect only at a falling edge of the card clock; a high phase already begun keeps its original length.
- R8: The bus-width output is 0 (1-bit bus) with bits 11 and 12 both clear, 1 (4-bit bus) with only bit 11 set, and 2 (8-bit bus) whenever bit 12 is set.
- R9: In divided mode the qualifier is high for exactly one master cycle per card clock period: the first cycle of each high phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ctrlReg | input | CTRL_W (15) | Clock control word: DIV, enable, power-save, pass-through, width bits, flow-control bit |
| fifoStall | input | 1 | FIFO can neither accept nor supply data |
| busActive | input | 1 | Data or command transfer in progress |
| cardClk | output | 1 | Card clock |
| cardClkEn | output | 1 | Qualifier: card clock has just risen (every cycle in pass-through) |
| busWidth | output | 2 | Decoded data bus width: 0 = 1 bit, 1 = 4 bits, 2 = 8 bits |

## Verification
The bench builds the block with an 8-bit DIV field and the flow-control enable placed on bit 14, so the non-default placement of that bit is the one exercised, and the full 0 to 255 range of DIV, including the 512-cycle slowest period, is reachable within a short run. A behavioural model tracks phase length, pending divisor and the falling-edge gate and is compared every cycle, while directed sequences retune DIV mid-high-phase, stall and release the FIFO, idle the bus in power-save mode and switch into pass-through.

// File: rtl/sdclk_pkg.sv
package sdclk_pkg;

  // Strobes from the control half to the counting half.
  typedef struct packed {
    logic clear;      // park the divider: counter zero, clock low
    logic bypass;     // master clock pass-through requested
    logic allowRise;  // no stop condition: a low-to-high step may happen
  } divCtlT;

  typedef enum logic [1:0] {
    BUS_1 = 2'd0,
    BUS_4 = 2'd1,
    BUS_8 = 2'd2
  } busWidthT;

endpackage

// File: rtl/sdclk_ctrl.sv
module sdclk_ctrl
  import sdclk_pkg::*;
#(
  parameter int DIV_W     = 8,
  parameter bit FLOW_HIGH = 1'b0,
  localparam int CTRL_W   = DIV_W + 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CTRL_W-1:0] ctrlReg,
  input  logic              fifoStall,
  input  logic              busActive,
  output divCtlT            divCtl,
  output logic [DIV_W-1:0]  divVal,
  output busWidthT          busWidth
);

  localparam int EN_BIT  = DIV_W;
  localparam int PS_BIT  = DIV_W + 1;
  localparam int BYP_BIT = DIV_W + 2;
  localparam int W4_BIT  = DIV_W + 3;
  localparam int W8_BIT  = DIV_W + 4;

  logic enBit, psBit, bypBit, wide4, wide8, flowBit;
  logic stallStop, idleStop;

  assign enBit  = ctrlReg[EN_BIT];
  assign psBit  = ctrlReg[PS_BIT];
  assign bypBit = ctrlReg[BYP_BIT];
  assign wide4  = ctrlReg[W4_BIT];
  assign wide8  = ctrlReg[W8_BIT];
  assign divVal = ctrlReg[DIV_W-1:0];

  // Flow-control enable sits on one of two positions.
  generate
    if (FLOW_HIGH) begin : g_flowHigh
      assign flowBit = ctrlReg[DIV_W + 6];
    end else begin : g_flowLow
      assign flowBit = ctrlReg[DIV_W + 5];
    end
  endgenerate

  assign stallStop = flowBit && fifoStall;
  assign idleStop  = psBit && !busActive;

  always_comb begin
    divCtl.clear     = !enBit || bypBit;
    divCtl.bypass    = enBit && bypBit;
    divCtl.allowRise = !stallStop && !idleStop;
  end

  always_comb begin
    if (wide8)      busWidth = BUS_8;
    else if (wide4) busWidth = BUS_4;
    else            busWidth = BUS_1;
  end

  AST_WIDTH_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    busWidth != 2'b11) else $error("illegal width code"); // R8

endmodule

// File: rtl/sdclk_datapath.sv
module sdclk_datapath
  import sdclk_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  divCtlT           divCtl,
  input  logic [DIV_W-1:0] divVal,
  output logic             cardClk,
  output logic             cardClkEn
);

  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] divAct;
  logic             divClk;
  logic             riseQual;
  logic             bypGate;
  logic             phaseEnd;

  assign phaseEnd = (cnt == divAct);

  // Divided clock: a phase lasts divAct+1 master cycles. The divisor is
  // reloaded only where the clock falls or while parked.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt      <= '0;
      divAct   <= '0;
      divClk   <= 1'b0;
      riseQual <= 1'b0;
    end else if (divCtl.clear) begin
      cnt      <= '0;
      divAct   <= divVal;
      divClk   <= 1'b0;
      riseQual <= 1'b0;
    end else if (phaseEnd) begin
      if (divClk) begin
        divClk   <= 1'b0;
        cnt      <= '0;
        divAct   <= divVal;
        riseQual <= 1'b0;
      end else if (divCtl.allowRise) begin
        divClk   <= 1'b1;
        cnt      <= '0;
        riseQual <= 1'b1;
      end else begin
        riseQual <= 1'b0;  // stopped: stay low at the end of the low phase
      end
    end else begin
      cnt      <= cnt + 1'b1;
      riseQual <= 1'b0;
    end
  end

  // Pass-through gate changes only while the master clock is low.
  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) bypGate <= 1'b0;
    else       bypGate <= divCtl.bypass && divCtl.allowRise;
  end

  assign cardClk   = (clk && bypGate) || divClk;
  assign cardClkEn = riseQual || bypGate;

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= divAct) else $error("counter past divisor"); // R1
  AST_PARK_LOW: assert property (@(posedge clk) disable iff (!rstN)
    divCtl.clear |=> (!divClk && !riseQual)) else $error("not parked"); // R4
  AST_RISE_ALLOWED: assert property (@(posedge clk) disable iff (!rstN)
    $rose(divClk) |-> $past(divCtl.allowRise)) else $error("rise while stopped"); // R5
  AST_DIV_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (divClk && $past(divClk)) |-> $stable(divAct)) else $error("divisor moved high"); // R7
  AST_QUAL_EDGE: assert property (@(posedge clk) disable iff (!rstN)
    riseQual |-> (divClk && !$past(divClk))) else $error("qualifier off edge"); // R9

endmodule

// File: rtl/sdclk_divider.sv
module sdclk_divider
  import sdclk_pkg::*;
#(
  parameter int DIV_W     = 8,
  parameter bit FLOW_HIGH = 1'b0,
  localparam int CTRL_W   = DIV_W + 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CTRL_W-1:0] ctrlReg,
  input  logic              fifoStall,
  input  logic              busActive,
  output logic              cardClk,
  output logic              cardClkEn,
  output logic [1:0]        busWidth
);

  divCtlT           divCtl;
  logic [DIV_W-1:0] divVal;
  busWidthT         widthCode;

  sdclk_ctrl #(.DIV_W(DIV_W), .FLOW_HIGH(FLOW_HIGH)) i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .ctrlReg   (ctrlReg),
    .fifoStall (fifoStall),
    .busActive (busActive),
    .divCtl    (divCtl),
    .divVal    (divVal),
    .busWidth  (widthCode)
  );

  sdclk_datapath #(.DIV_W(DIV_W)) i_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .divCtl    (divCtl),
    .divVal    (divVal),
    .cardClk   (cardClk),
    .cardClkEn (cardClkEn)
  );

  assign busWidth = widthCode;

endmodule

// File: tb/test_sdclk_divider.sv
`timescale 1ns/1ps
module test_sdclk_divider;

  localparam int EN_B = 8, PS_B = 9, BYP_B = 10, W4_B = 11, W8_B = 12, FC_B = 14;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [14:0] ctrlReg = '0;
  logic        fifoStall = 1'b0;
  logic        busActive = 1'b0;
  logic        cardClk, cardClkEn;
  logic [1:0]  busWidth;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  sdclk_divider #(.DIV_W(8), .FLOW_HIGH(1'b1)) i_sdclk_divider (
    .clk(clk), .rstN(rstN), .ctrlReg(ctrlReg), .fifoStall(fifoStall),
    .busActive(busActive), .cardClk(cardClk), .cardClkEn(cardClkEn),
    .busWidth(busWidth)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [14:0] mk(input int dv, input bit en, input bit ps,
                                     input bit byp, input bit w4, input bit w8, input bit fc);
    logic [14:0] v;
    v = '0;
    v[7:0] = dv[7:0];
    v[EN_B] = en; v[PS_B] = ps; v[BYP_B] = byp;
    v[W4_B] = w4; v[W8_B] = w8; v[FC_B] = fc;
    return v;
  endfunction

  function automatic bit runOk();
    return !(ctrlReg[FC_B] && fifoStall) && !(ctrlReg[PS_B] && !busActive);
  endfunction

  function automatic int expWidth();
    if (ctrlReg[W8_B]) return 2;
    if (ctrlReg[W4_B]) return 1;
    return 0;
  endfunction

  // Behavioural reference
  int mCnt, mDiv;
  bit mClk, mQual, mGate;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mCnt = 0; mDiv = 0; mClk = 0; mQual = 0;
    end else begin
      mQual = 0;
      if (!ctrlReg[EN_B] || ctrlReg[BYP_B]) begin
        mCnt = 0; mClk = 0; mDiv = int'(ctrlReg[7:0]);
      end else if (mCnt == mDiv) begin
        if (mClk) begin
          mClk = 0; mCnt = 0; mDiv = int'(ctrlReg[7:0]);
        end else if (runOk()) begin
          mClk = 1; mCnt = 0; mQual = 1;
        end
      end else begin
        mCnt++;
      end
    end
  end

  always @(negedge clk or negedge rstN) begin
    if (!rstN) mGate = 0;
    else       mGate = ctrlReg[EN_B] && ctrlReg[BYP_B] && runOk();
  end

  always @(posedge clk) begin
    #1;
    if (rstN && !done) begin
      check(cardClk == (mClk | mGate), "R1 per-cycle card clock", cardClk, mClk | mGate);
      check(cardClkEn == (mQual | mGate), "R9 per-cycle qualifier", cardClkEn, mQual | mGate);
      check(int'(busWidth) == expWidth(), "R8 per-cycle bus width", busWidth, expWidth());
    end
  end

  task automatic drive(input logic [14:0] v);
    @(posedge clk); #3;
    ctrlReg = v;
  endtask

  task automatic sample();
    @(posedge clk); #1;
  endtask

  task automatic waitPulse(output int n);
    n = 0;
    do begin sample(); n++; end while (!cardClkEn && n < 2000);
  endtask

  task automatic measure(input int expP, input string tag);
    int n;
    waitPulse(n); waitPulse(n); waitPulse(n);
    waitPulse(n);
    check(n == expP, tag, n, expP);
  endtask

  task automatic countHigh(input int cycles, output int hi, output int pulses);
    hi = 0; pulses = 0;
    for (int i = 0; i < cycles; i++) begin
      sample();
      if (cardClk) hi++;
      if (cardClkEn) pulses++;
    end
  endtask

  initial begin
    #400000;
    if (!done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int hi, lo, pulses, n, bad;
    repeat (3) @(posedge clk);
    #1;
    check(cardClk == 0, "R4 reset card clock", cardClk, 0);
    check(cardClkEn == 0, "R4 reset qualifier", cardClkEn, 0);
    check(busWidth == 0, "R8 reset width", busWidth, 0);
    #2 rstN = 1'b1;

    // R1: several divisors
    drive(mk(0, 1, 0, 0, 0, 0, 0));
    measure(2, "R1 period DIV=0");
    drive(mk(3, 1, 0, 0, 0, 0, 0));
    measure(8, "R1 period DIV=3");
    drive(mk(6, 1, 0, 0, 0, 0, 0));
    measure(14, "R1 period DIV=6");

    // R2: slowest
    drive(mk(255, 1, 0, 0, 0, 0, 0));
    measure(512, "R2 period DIV=255");

    // R7: retune during a high phase
    drive(mk(3, 1, 0, 0, 0, 0, 0));
    waitPulse(n); waitPulse(n); waitPulse(n);
    #2;
    ctrlReg = mk(1, 1, 0, 0, 0, 0, 0);
    hi = 1;
    forever begin sample(); if (cardClk) hi++; else break; end
    lo = 1;
    forever begin sample(); if (!cardClk) lo++; else break; end
    check(hi == 4, "R7 high phase keeps old DIV", hi, 4);
    check(lo == 2, "R7 low phase uses new DIV", lo, 2);

    // R4: disabled
    drive(mk(2, 0, 0, 0, 0, 0, 0));
    countHigh(40, hi, pulses);
    check(hi == 0, "R4 disabled card clock highs", hi, 0);
    check(pulses == 0, "R4 disabled qualifier pulses", pulses, 0);

    // R3: pass-through, DIV ignored
    drive(mk(5, 1, 0, 1, 0, 0, 0));
    repeat (2) sample();
    bad = 0;
    for (int i = 0; i < 10; i++) begin
      sample();
      if (!cardClk) bad++;
      #2;
      if (cardClk) bad++;
    end
    check(bad == 0, "R3 pass-through follows master", bad, 0);

    // R5: flow-control stall
    drive(mk(1, 1, 0, 0, 0, 0, 1));
    fifoStall = 1'b1;
    repeat (6) sample();
    countHigh(30, hi, pulses);
    check(hi == 0, "R5 stalled clock held low", hi, 0);
    #2 fifoStall = 1'b0;
    countHigh(20, hi, pulses);
    check(pulses > 0, "R5 clock resumes after stall", pulses, 1);
    drive(mk(1, 1, 0, 0, 0, 0, 0));
    fifoStall = 1'b1;
    countHigh(20, hi, pulses);
    check(pulses == 5, "R5 stall ignored with control bit clear", pulses, 5);
    #2 fifoStall = 1'b0;

    // R6: power-save
    drive(mk(1, 1, 1, 0, 0, 0, 0));
    busActive = 1'b0;
    repeat (6) sample();
    countHigh(30, hi, pulses);
    check(hi == 0, "R6 idle bus stops clock", hi, 0);
    #2 busActive = 1'b1;
    countHigh(20, hi, pulses);
    check(pulses > 0, "R6 active bus runs clock", pulses, 1);
    #2 busActive = 1'b0;

    // R8: width decode
    drive(mk(1, 1, 0, 0, 1, 0, 0)); sample();
    check(busWidth == 1, "R8 4-bit select", busWidth, 1);
    drive(mk(1, 1, 0, 0, 0, 1, 0)); sample();
    check(busWidth == 2, "R8 8-bit select", busWidth, 2);
    drive(mk(1, 1, 0, 0, 1, 1, 0)); sample();
    check(busWidth == 2, "R8 both bits set", busWidth, 2);
    drive(mk(1, 1, 0, 0, 0, 0, 0)); sample();
    check(busWidth == 0, "R8 1-bit default", busWidth, 0);

    // R9: one qualifier per period
    drive(mk(4, 1, 0, 0, 0, 0, 0));
    repeat (30) sample();
    countHigh(100, hi, pulses);
    check(pulses == 10, "R9 one qualifier per period", pulses, 10);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule